// File: doc/BRIEF.md
# Multi-Mode UART Bit-Timing Generator

This block derives the per-bit timing that a UART's receive and transmit shifters need. It works from one clock and splits it in two stages. A 16-bit prescaler divides the clock into sample slots. An oversampling counter then groups a number of slots into one bit period. A 2-bit speed mode sets how many slots make up one bit: 16, 4, or a software-chosen count of up to 256. It also sets which slot is flagged as the data sample.

Software programs the block through a byte-wide register port with combinational read-back. The divisor bytes share two addresses with a data byte and an interrupt-enable byte. Bit 7 of the line-control register selects which of the two is reached. The usual sequence is to write 0x83, then the two divisor bytes, then 0x03.

The outputs are:
- `bit_tick`: one cycle at the end of every bit period.
- `samp_strobe`: one cycle at the end of the selected sample slot.
- `samp_idx`: the current slot index.

A receiver pulses `rx_start` on a detected start edge. This restarts the timing so that sampling lines up with the incoming start bit.

Top module: `baud_sample_gen`

## Requirements
- R1: After reset the divisor is 1, line control is 0x00, speed mode is 0, sample-count reads 15, sample-point reads 7, and the data and interrupt-enable bytes are 0. During reset `samp_idx` is 0 and `bit_tick` is low.
- R2: Address 0 reaches the divisor low byte and address 1 the divisor high byte while line-control bit 7 is 1. While that bit is 0, the same addresses reach the data byte and the interrupt-enable byte instead. The other mapped addresses are 3 (line control), 9 (speed mode, bits 1:0), 10 (sample count) and 11 (sample point). Unmapped addresses read 0.
- R3: In speed mode 0, and in the reserved mode 1 that behaves identically, a bit lasts 16 × divisor cycles. The strobe fires at slot index 7.
- R4: In speed mode 2 a bit lasts 4 × divisor cycles and the strobe fires at slot index 1.
- R5: In speed mode 3 a bit lasts (sample_count + 1) × divisor cycles and the strobe fires at the slot whose index equals sample_point. In modes 0, 1 and 2 the sample-point register has no effect.
- R6: A divisor value of 0 acts as 1.
- R7: The following writes restart the timing: a write to either divisor byte with bit 7 set, and any write to the speed-mode register. After such a write, the next cycle shows prescaler 0 and `samp_idx` 0. Writes to the data or interrupt-enable byte do not disturb the timing.
- R8: A one-cycle `rx_start` pulse restarts the timing. The next cycle shows `samp_idx` 0, and the following bit tick comes after a full bit period.
- R9: `samp_idx` advances by one each time the prescaler completes a slot. After the last slot it returns to 0, and `bit_tick` is high in that final cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Baud and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| rx_start | input | 1 | Receive start-edge pulse, restarts timing |
| bit_tick | output | 1 | End-of-bit pulse |
| samp_strobe | output | 1 | Data-sample pulse |
| samp_idx | output | 8 | Current sample slot index |

## Verification
The bench builds the block with its default widths, a 16-bit divisor and an 8-bit sample counter. It uses divisors of 0 to 3 so that full bit periods in every speed mode fit in a short run. These small divisors also bring the divide-by-one prescaler corner, the zero-divisor substitution and slot-by-slot index stepping within reach. In mode 3 a sample count of 9 with sample point 4 exercises a non-power-of-two bit length and an off-centre strobe.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  localparam int DIV_W  = 16;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_DLO  = 4'd0;
  localparam logic [ADDR_W-1:0] A_DHI  = 4'd1;
  localparam logic [ADDR_W-1:0] A_LCTL = 4'd3;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd9;
  localparam logic [ADDR_W-1:0] A_SCNT = 4'd10;
  localparam logic [ADDR_W-1:0] A_SPT  = 4'd11;

  typedef enum logic [1:0] {
    SPD_X16  = 2'd0,
    SPD_RSVD = 2'd1,
    SPD_X4   = 2'd2,
    SPD_PROG = 2'd3
  } speed_e;

  // a zero divisor is replaced by one
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  // index of the last slot in a bit
  function automatic logic [CNT_W-1:0] last_slot(input speed_e m,
                                                 input logic [CNT_W-1:0] scnt);
    case (m)
      SPD_X4:   return CNT_W'(3);
      SPD_PROG: return scnt;
      default:  return CNT_W'(15);
    endcase
  endfunction

  // slot flagged as the data sample
  function automatic logic [CNT_W-1:0] samp_slot(input speed_e m,
                                                 input logic [CNT_W-1:0] spt);
    case (m)
      SPD_X4:   return CNT_W'(1);
      SPD_PROG: return spt;
      default:  return CNT_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/bsg_regfile.sv
module bsg_regfile
  import bsg_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [DW-1:0]     div_q,
  output speed_e            mode_q,
  output logic [CW-1:0]     scnt_q,
  output logic [CW-1:0]     spt_q,
  output logic              div_wr,
  output logic              mode_wr
);
  localparam int HI_W = DW - 8;

  logic [7:0] lctl_q, data_q, ien_q;
  logic       latch_open;

  assign latch_open = lctl_q[7];
  assign div_wr  = wr_en && latch_open && (addr == A_DLO || addr == A_DHI);
  assign mode_wr = wr_en && (addr == A_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DW'(1);
      lctl_q <= 8'h00;
      mode_q <= SPD_X16;
      scnt_q <= CW'(15);
      spt_q  <= CW'(7);
      data_q <= 8'h00;
      ien_q  <= 8'h00;
    end else if (wr_en) begin
      case (addr)
        A_DLO:  if (latch_open) div_q[7:0] <= wdata;
                else            data_q     <= wdata;
        A_DHI:  if (latch_open) div_q[DW-1:8] <= wdata[HI_W-1:0];
                else            ien_q         <= wdata;
        A_LCTL: lctl_q <= wdata;
        A_MODE: mode_q <= speed_e'(wdata[1:0]);
        A_SCNT: scnt_q <= wdata[CW-1:0];
        A_SPT:  spt_q  <= wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_DLO:  rdata = latch_open ? div_q[7:0] : data_q;
      A_DHI:  rdata = latch_open ? 8'(div_q[DW-1:8]) : ien_q;
      A_LCTL: rdata = lctl_q;
      A_MODE: rdata = {6'b0, mode_q};
      A_SCNT: rdata = 8'(scnt_q);
      A_SPT:  rdata = 8'(spt_q);
      default: rdata = 8'h00;
    endcase
  end

  // R2: closed latch keeps the divisor untouched
  p_div_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !latch_open && (addr == A_DLO || addr == A_DHI)) |=> $stable(div_q));
endmodule

// File: rtl/bsg_prescaler.sv
module bsg_prescaler
  import bsg_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [DW-1:0] div,
  output logic          pre_wrap
);
  logic [DW-1:0] pre_cnt;
  logic [DW-1:0] limit;

  assign limit    = eff_div(div) - DW'(1);
  assign pre_wrap = (pre_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_cnt <= '0;
    else if (restart)   pre_cnt <= '0;
    else if (pre_wrap)  pre_cnt <= '0;
    else                pre_cnt <= pre_cnt + DW'(1);
  end

  // R6: count never passes the effective divisor
  p_pre_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= limit);
  // R7: restart leaves the prescaler at zero
  p_pre_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pre_cnt == '0);
endmodule

// File: rtl/bsg_oversampler.sv
module bsg_oversampler
  import bsg_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          pre_wrap,
  input  speed_e        mode,
  input  logic [CW-1:0] scnt,
  input  logic [CW-1:0] spt,
  output logic          bit_tick,
  output logic          samp_strobe,
  output logic [CW-1:0] samp_idx
);
  logic [CW-1:0] last, pick;
  logic          at_last;

  assign last        = last_slot(mode, scnt);
  assign pick        = samp_slot(mode, spt);
  assign at_last     = (samp_idx >= last);
  assign bit_tick    = pre_wrap && at_last;
  assign samp_strobe = pre_wrap && (samp_idx == pick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        samp_idx <= '0;
    else if (restart)  samp_idx <= '0;
    else if (pre_wrap) samp_idx <= at_last ? '0 : samp_idx + CW'(1);
  end

  // R9: end of bit returns the index to zero
  p_tick_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> samp_idx == '0);
  // R9: mid-bit slot completion steps the index by one
  p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wrap && !bit_tick && !restart) |=> samp_idx == $past(samp_idx) + CW'(1));
  // R9: index holds while the prescaler is mid-slot
  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_wrap && !restart) |=> $stable(samp_idx));
  // R8: restart from a start edge clears the index
  p_idx_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> samp_idx == '0);
endmodule

// File: rtl/baud_sample_gen.sv
module baud_sample_gen
  import bsg_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              rx_start,
  output logic              bit_tick,
  output logic              samp_strobe,
  output logic [CW-1:0]     samp_idx
);
  logic [DW-1:0] div_q;
  speed_e        mode_q;
  logic [CW-1:0] scnt_q, spt_q;
  logic          div_wr, mode_wr, restart, pre_wrap;

  assign restart = div_wr || mode_wr || rx_start;

  bsg_regfile #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .div_q(div_q), .mode_q(mode_q), .scnt_q(scnt_q),
    .spt_q(spt_q), .div_wr(div_wr), .mode_wr(mode_wr)
  );

  bsg_prescaler #(.DW(DW)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div(div_q),
    .pre_wrap(pre_wrap)
  );

  bsg_oversampler #(.CW(CW)) u_ovs (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pre_wrap(pre_wrap),
    .mode(mode_q), .scnt(scnt_q), .spt(spt_q), .bit_tick(bit_tick),
    .samp_strobe(samp_strobe), .samp_idx(samp_idx)
  );

  // R3/R4/R5: strobe and tick only at slot boundaries
  p_pulse_on_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick || samp_strobe) |-> pre_wrap);
endmodule

// File: tb/baud_sample_gen_bench.sv
module baud_sample_gen_bench;
  logic       clk = 0, rst_n = 0, wr_en = 0, rx_start = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata, samp_idx;
  logic       bit_tick, samp_strobe;
  int vecs = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_sample_gen u_baud_sample_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rx_start(rx_start), .bit_tick(bit_tick),
    .samp_strobe(samp_strobe), .samp_idx(samp_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, compared on every falling edge
  int m_div, m_lc, m_mode, m_sc, m_sp, m_dat, m_ie, m_pre, m_idx;
  always @(negedge clk) begin
    int d, lst, pk, rd;
    bit wrap, rs;
    string t;
    if (!rst_n) begin
      m_div = 1; m_lc = 0; m_mode = 0; m_sc = 15; m_sp = 7;
      m_dat = 0; m_ie = 0; m_pre = 0; m_idx = 0;
    end else begin
      d   = (m_div == 0) ? 1 : m_div;
      lst = (m_mode == 3) ? m_sc : (m_mode == 2) ? 3 : 15;
      pk  = (m_mode == 3) ? m_sp : (m_mode == 2) ? 1 : 7;
      t   = (m_mode == 3) ? "R5" : (m_mode == 2) ? "R4" : "R3";
      wrap = (m_pre == d - 1);
      chk({t, " bit_tick"}, bit_tick, wrap && m_idx >= lst);
      chk({t, " samp_strobe"}, samp_strobe, wrap && m_idx == pk);
      chk({t, " samp_idx"}, samp_idx, m_idx);
      case (addr)
        0: rd = m_lc[7] ? (m_div & 255) : m_dat;
        1: rd = m_lc[7] ? (m_div >> 8) : m_ie;
        3: rd = m_lc;
        9: rd = m_mode;
        10: rd = m_sc;
        11: rd = m_sp;
        default: rd = 0;
      endcase
      chk("R2 rdata", rdata, rd);
      rs = rx_start || (wr_en && addr == 9) || (wr_en && m_lc[7] && addr <= 1);
      if (rs) begin m_pre = 0; m_idx = 0; end
      else if (wrap) begin m_pre = 0; m_idx = (m_idx >= lst) ? 0 : m_idx + 1; end
      else m_pre++;
      if (wr_en) case (addr)
        0: if (m_lc[7]) m_div = (m_div & 16'hff00) | wdata; else m_dat = wdata;
        1: if (m_lc[7]) m_div = (m_div & 255) | (int'(wdata) << 8); else m_ie = wdata;
        3: m_lc = wdata;
        9: m_mode = wdata[1:0];
        10: m_sc = wdata;
        11: m_sp = wdata;
        default: ;
      endcase
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1; wr_en = 1; addr = 4'(a); wdata = 8'(d);
    @(posedge clk); #1; wr_en = 0;
  endtask
  task automatic rd(input int a, input int exp, input string tag);
    @(posedge clk); #1; addr = 4'(a);
    @(negedge clk); chk({tag, " read"}, rdata, exp);
  endtask
  task automatic wt(output int c);
    do @(negedge clk); while (!bit_tick);
    c = cyc;
  endtask
  task automatic period(input int exp, input string tag);
    int a, b;
    wt(a); wt(b);
    chk({tag, " bit period"}, b - a, exp);
  endtask
  task automatic strobe_at(input int exp, input string tag);
    do @(negedge clk); while (!samp_strobe);
    chk({tag, " strobe index"}, samp_idx, exp);
  endtask
  task automatic set_div(input int d);
    wr(3, 8'h83); wr(0, d & 255); wr(1, d >> 8); wr(3, 8'h03);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int a, b;
    repeat (3) @(negedge clk);
    chk("R1 reset samp_idx", samp_idx, 0);
    chk("R1 reset bit_tick", bit_tick, 0);
    @(posedge clk); #1; rst_n = 1;
    rd(9, 0, "R1"); rd(10, 15, "R1"); rd(11, 7, "R1"); rd(3, 0, "R1");
    rd(0, 0, "R1"); rd(1, 0, "R1");
    wr(3, 8'h83); rd(0, 1, "R1"); rd(1, 0, "R1");
    // aliasing
    wr(0, 3); wr(1, 0); wr(3, 8'h03);
    wr(0, 8'hA5); wr(1, 8'h5A);
    rd(0, 8'hA5, "R2"); rd(1, 8'h5A, "R2"); rd(5, 0, "R2");
    wr(3, 8'h83); rd(0, 3, "R2"); rd(1, 0, "R2"); wr(3, 8'h03);
    // mode 0 and reserved mode 1
    period(48, "R3");
    wr(9, 1); rd(9, 1, "R3"); period(48, "R3");
    wr(11, 2); strobe_at(7, "R5");
    // mode 2
    wr(9, 2); period(12, "R4"); strobe_at(1, "R4");
    // mode 3
    wr(10, 9); wr(11, 4); wr(9, 3); period(30, "R5"); strobe_at(4, "R5");
    // index stepping
    set_div(1); wr(9, 2);
    wt(a);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R9 samp_idx step", samp_idx, i);
    end
    // zero divisor
    set_div(0); wr(9, 0); period(16, "R6");
    // data write does not disturb timing
    wt(a); wr(0, 8'h11); wt(b); chk("R7 period across data write", b - a, 16);
    // mode write restarts
    wt(a); repeat (3) @(negedge clk); wr(9, 0);
    @(negedge clk); chk("R7 idx after mode write", samp_idx, 0);
    // start edge restart
    repeat (5) @(negedge clk);
    @(posedge clk); #1; rx_start = 1;
    @(posedge clk); #1; rx_start = 0;
    @(negedge clk); chk("R8 idx after rx_start", samp_idx, 0);
    a = cyc; wt(b); chk("R8 first period after rx_start", b - a, 15);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule